// File: doc/BRIEF.md
# ATA Device Task-File Status Controller

This block is the device-side register logic that a parallel ATA disk presents to its host for status and control. The host reaches it through register strobes: two chip selects, a three-bit register address, read and write strobes and an eight-bit data bus. The drive side reports readiness, faults, seek completion, data requests, the index pulse, the write gate, the selected head and command completion. The block combines these into the status byte, keeps the sticky error and seek flags, and owns the interrupt request line.

A command write is accepted only when the drive is idle and ready. It sets busy and hands the command code to the drive. When the drive finishes, or aborts on a fault or loss of readiness, busy drops and an interrupt is posted. The interrupt stays pending until the host reads the primary status or writes a new command. The device control register can float the interrupt line or hold the device in soft reset. A read-only diagnostic register reports the write gate, the head and the drive selects in inverted form.

Top module: `tfs_ctrl`

## Requirements
- R1: Reads are decoded as follows, where cs0/cs1 means exactly one chip select is active. cs0 address 7 is status. cs1 address 6 is alternate status. cs1 address 7 is the diagnostic register. These drive `host_rdata_oe` = 8'hFF, except the diagnostic register, which drives 8'h7F so that bit 7 floats. With neither chip select active, `host_rdata_oe` is 0.
- R2: Status bits, from bit 7 down to bit 0, are busy, ready, fault, seek-done, data-request, corrected, index, error. Ready, data-request and index follow the drive inputs directly. The corrected bit (bit 2) always reads 0.
- R3: A host read of status clears a pending interrupt. A read of alternate status returns the same byte and leaves the interrupt pending.
- R4: A write to cs0 address 7 starts a command only when busy is 0 and `drv_ready` is 1. An accepted write sets busy, clears the fault and error flags, and latches the code on `cmd_code`. Any command write clears a pending interrupt. A write that is not accepted leaves busy and the error flags unchanged.
- R5: `drv_cmd_done` while busy clears busy and posts an interrupt.
- R6: Seek-done is 0 after reset and sets on the first cycle the drive is ready. It is cleared by an accepted command whose code is 1xh, 2xh, 3xh, 4xh, 5xh, 7xh, C4h, C5h or C8h to CBh. It is set again by `drv_seek_done`.
- R7: `drv_fault` while busy ends the command. Busy clears, fault and error set, and an interrupt posts. Fault and error stay set until the next accepted command.
- R8: `drv_ready` falling while busy ends the command. Busy clears, error sets, and an interrupt posts.
- R9: Device control bit 1 is the interrupt disable. When it is 1, `intrq_oe` is 0. When it is 0, `intrq_oe` is 1 only while the drive-select bit (bit 4 of a write to cs0 address 6) matches `dev_is_slave`.
- R10: Device control bit 2 is soft reset, and it takes effect whatever the drive-select bit holds. While it is 1, status bit 7 reads 1 and all flags, the pending interrupt and the drive select return to their reset values. After release, seek-done sets again once the drive is ready.
- R11: Device control bits 7 to 3 and bit 0 are ignored on write.
- R12: Diagnostic register bit 6 is the inverted write gate. Bits 5 to 2 are the one's complement of `drv_head`. Bit 1 is low while this device is the slave and is selected. Bit 0 is low while this device is the master and is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs0 | input | 1 | Command-block chip select, active high |
| host_cs1 | input | 1 | Control-block chip select, active high |
| host_addr | input | 3 | Register address |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| host_rdata_oe | output | 8 | Per-bit read data drive enable |
| intrq | output | 1 | Interrupt request level |
| intrq_oe | output | 1 | Interrupt line drive enable (0 = high impedance) |
| dev_is_slave | input | 1 | Strap: this device answers to drive select 1 |
| drv_ready | input | 1 | Drive ready |
| drv_fault | input | 1 | Drive fault |
| drv_seek_done | input | 1 | Seek completion pulse |
| drv_drq | input | 1 | Sector buffer needs data |
| drv_index | input | 1 | Index pulse |
| drv_wgate | input | 1 | Write gate active |
| drv_head | input | 4 | Currently selected head |
| drv_cmd_done | input | 1 | Command completion pulse |
| cmd_start | output | 1 | One-cycle pulse on an accepted command |
| cmd_code | output | 8 | Code of the last accepted command |

## Verification
The command path is driven with a seek-type code and a non-seek code. This separates seek-done clearing from busy setting. Completion, fault abort and readiness loss are each raised against a busy command, so that each termination path shows its own status byte. Interrupts are posted with the line enabled, disabled and deselected, and then read back through both status addresses to tell acknowledgement from a plain observation. The diagnostic register is swept over all sixteen heads with alternating write gate under both master and slave straps, and soft reset is applied with the other drive selected.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    localparam int DATA_W = 8;
    localparam int HEAD_W = 4;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CS0_DEVHD  = 3'd6;
    localparam logic [ADDR_W-1:0] A_CS0_STATUS = 3'd7;
    localparam logic [ADDR_W-1:0] A_CS1_CTRL   = 3'd6;
    localparam logic [ADDR_W-1:0] A_CS1_DIAG   = 3'd7;

    localparam int CTL_NIEN_BIT = 1;
    localparam int CTL_SRST_BIT = 2;
    localparam int DEV_SEL_BIT  = 4;

    typedef struct packed {
        logic bsy;
        logic drdy;
        logic df;
        logic dsc;
        logic drq;
        logic corr;
        logic idx;
        logic err;
    } stat_t;

    typedef struct packed {
        logic wr_cmd;
        logic wr_devhd;
        logic wr_ctl;
        logic rd_stat;
        logic rd_alt;
        logic rd_diag;
    } hstrobe_t;

    function automatic logic cmd_has_seek(input logic [DATA_W-1:0] code);
        logic [3:0] hi;
        hi = code[7:4];
        case (hi)
            4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h7: return 1'b1;
            4'hC: return (code[3:0] == 4'h4) || (code[3:0] == 4'h5) ||
                         (code[3:2] == 2'b10);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] diag_pack(
        input logic              wgate,
        input logic [HEAD_W-1:0] head,
        input logic              slave_n,
        input logic              master_n);
        return {1'b0, ~wgate, ~head, slave_n, master_n};
    endfunction

endpackage

// File: rtl/tfs_decode.sv
module tfs_decode
    import tfs_pkg::*;
(
    input  logic              cs0,
    input  logic              cs1,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output hstrobe_t          stb
);
    logic only0, only1;

    always_comb begin
        only0 = cs0 && !cs1;
        only1 = cs1 && !cs0;
        stb.wr_cmd   = wr && only0 && (addr == A_CS0_STATUS);
        stb.wr_devhd = wr && only0 && (addr == A_CS0_DEVHD);
        stb.wr_ctl   = wr && only1 && (addr == A_CS1_CTRL);
        stb.rd_stat  = rd && only0 && (addr == A_CS0_STATUS);
        stb.rd_alt   = rd && only1 && (addr == A_CS1_CTRL);
        stb.rd_diag  = rd && only1 && (addr == A_CS1_DIAG);
    end
endmodule

// File: rtl/tfs_core.sv
module tfs_core
    import tfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stat_rd,
    input  logic              drv_ready,
    input  logic              drv_fault,
    input  logic              drv_seek_done,
    input  logic              drv_cmd_done,
    output logic              busy,
    output logic              df,
    output logic              dsc,
    output logic              err,
    output logic              pend,
    output logic              cmd_start,
    output logic [DATA_W-1:0] cmd_code
);
    logic booted;
    logic accept, abort, finish;

    always_comb begin
        accept = cmd_wr && !busy && drv_ready;
        abort  = busy && (drv_fault || !drv_ready);
        finish = busy && drv_cmd_done && !abort;
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            busy      <= 1'b0;
            df        <= 1'b0;
            dsc       <= 1'b0;
            err       <= 1'b0;
            pend      <= 1'b0;
            booted    <= 1'b0;
            cmd_start <= 1'b0;
            cmd_code  <= '0;
        end else begin
            cmd_start <= accept;
            if (!booted && drv_ready) begin
                booted <= 1'b1;
                dsc    <= 1'b1;
            end
            if (drv_seek_done)
                dsc <= 1'b1;
            if (accept) begin
                busy     <= 1'b1;
                df       <= 1'b0;
                err      <= 1'b0;
                pend     <= 1'b0;
                cmd_code <= wdata;
                if (cmd_has_seek(wdata))
                    dsc <= 1'b0;
            end else if (abort) begin
                busy <= 1'b0;
                err  <= 1'b1;
                pend <= 1'b1;
                if (drv_fault)
                    df <= 1'b1;
            end else if (finish) begin
                busy <= 1'b0;
                pend <= 1'b1;
            end else if (cmd_wr || stat_rd) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tfs_ctlreg.sv
module tfs_ctlreg
    import tfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic              wr_devhd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dev_is_slave,
    input  logic              pend,
    output logic              srst,
    output logic              nien,
    output logic              dev_sel,
    output logic              intrq,
    output logic              intrq_oe,
    output logic              slave_n,
    output logic              master_n
);
    logic selected;

    always_ff @(posedge clk) begin
        if (rst) begin
            srst <= 1'b0;
            nien <= 1'b0;
        end else if (wr_ctl) begin
            srst <= wdata[CTL_SRST_BIT];
            nien <= wdata[CTL_NIEN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst)
            dev_sel <= 1'b0;
        else if (wr_devhd)
            dev_sel <= wdata[DEV_SEL_BIT];
    end

    always_comb begin
        selected = (dev_sel == dev_is_slave);
        intrq    = pend;
        intrq_oe = !nien && selected;
        slave_n  = !(dev_is_slave && selected);
        master_n = !(!dev_is_slave && selected);
    end
endmodule

// File: rtl/tfs_rdmux.sv
module tfs_rdmux
    import tfs_pkg::*;
(
    input  hstrobe_t          stb,
    input  stat_t             stat,
    input  logic [DATA_W-1:0] diag,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] rdata_oe
);
    localparam logic [DATA_W-1:0] ALL_ON  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] DIAG_ON = {1'b0, {(DATA_W-1){1'b1}}};

    always_comb begin
        rdata    = '0;
        rdata_oe = '0;
        if (stb.rd_stat || stb.rd_alt) begin
            rdata    = stat;
            rdata_oe = ALL_ON;
        end else if (stb.rd_diag) begin
            rdata    = diag;
            rdata_oe = DIAG_ON;
        end
    end
endmodule

// File: rtl/tfs_ctrl.sv
module tfs_ctrl
    import tfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs0,
    input  logic              host_cs1,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] host_rdata_oe,
    output logic              intrq,
    output logic              intrq_oe,
    input  logic              dev_is_slave,
    input  logic              drv_ready,
    input  logic              drv_fault,
    input  logic              drv_seek_done,
    input  logic              drv_drq,
    input  logic              drv_index,
    input  logic              drv_wgate,
    input  logic [HEAD_W-1:0] drv_head,
    input  logic              drv_cmd_done,
    output logic              cmd_start,
    output logic [DATA_W-1:0] cmd_code
);
    hstrobe_t          stb;
    stat_t             stat;
    logic              busy_i, df_i, dsc_i, err_i, pend_i;
    logic              srst_i, nien_i, dev_sel_i, slave_n, master_n;
    logic [DATA_W-1:0] diag;

    tfs_decode u_dec (
        .cs0  (host_cs0),
        .cs1  (host_cs1),
        .addr (host_addr),
        .rd   (host_rd),
        .wr   (host_wr),
        .stb  (stb)
    );

    tfs_core u_core (
        .clk           (clk),
        .rst           (rst),
        .srst          (srst_i),
        .cmd_wr        (stb.wr_cmd),
        .wdata         (host_wdata),
        .stat_rd       (stb.rd_stat),
        .drv_ready     (drv_ready),
        .drv_fault     (drv_fault),
        .drv_seek_done (drv_seek_done),
        .drv_cmd_done  (drv_cmd_done),
        .busy          (busy_i),
        .df            (df_i),
        .dsc           (dsc_i),
        .err           (err_i),
        .pend          (pend_i),
        .cmd_start     (cmd_start),
        .cmd_code      (cmd_code)
    );

    tfs_ctlreg u_ctl (
        .clk          (clk),
        .rst          (rst),
        .wr_ctl       (stb.wr_ctl),
        .wr_devhd     (stb.wr_devhd),
        .wdata        (host_wdata),
        .dev_is_slave (dev_is_slave),
        .pend         (pend_i),
        .srst         (srst_i),
        .nien         (nien_i),
        .dev_sel      (dev_sel_i),
        .intrq        (intrq),
        .intrq_oe     (intrq_oe),
        .slave_n      (slave_n),
        .master_n     (master_n)
    );

    always_comb begin
        stat.bsy  = busy_i || srst_i;
        stat.drdy = drv_ready;
        stat.df   = df_i;
        stat.dsc  = dsc_i;
        stat.drq  = drv_drq;
        stat.corr = 1'b0;
        stat.idx  = drv_index;
        stat.err  = err_i;
        diag      = diag_pack(drv_wgate, drv_head, slave_n, master_n);
    end

    tfs_rdmux u_mux (
        .stb      (stb),
        .stat     (stat),
        .diag     (diag),
        .rdata    (host_rdata),
        .rdata_oe (host_rdata_oe)
    );
endmodule

// File: rtl/tfs_ctrl_chk.sv
module tfs_ctrl_chk
    import tfs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_cs0,
    input logic              host_cs1,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic [DATA_W-1:0] host_rdata_oe,
    input logic              intrq,
    input logic              intrq_oe,
    input logic              drv_ready,
    input logic              drv_fault,
    input logic              drv_cmd_done,
    input logic [HEAD_W-1:0] drv_head,
    input logic              busy_i,
    input logic              df_i,
    input logic              srst_i
);
    logic rd_st, rd_al, rd_dg, wr_cm, wr_ct;
    assign rd_st = host_rd && host_cs0 && !host_cs1 && host_addr == A_CS0_STATUS;
    assign rd_al = host_rd && host_cs1 && !host_cs0 && host_addr == A_CS1_CTRL;
    assign rd_dg = host_rd && host_cs1 && !host_cs0 && host_addr == A_CS1_DIAG;
    assign wr_cm = host_wr && host_cs0 && !host_cs1 && host_addr == A_CS0_STATUS;
    assign wr_ct = host_wr && host_cs1 && !host_cs0 && host_addr == A_CS1_CTRL;

    a_r1_idle_bus: assert property (@(posedge clk) disable iff (rst)
        (!host_cs0 && !host_cs1) |-> (host_rdata_oe == '0));

    a_r2_corr_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_st || rd_al) |-> !host_rdata[2]);

    a_r3_alt_keeps: assert property (@(posedge clk) disable iff (rst)
        (rd_al && intrq && !host_wr) |=> intrq);

    a_r3_stat_acks: assert property (@(posedge clk) disable iff (rst)
        (rd_st && !busy_i) |=> !intrq);

    a_r4_accept: assert property (@(posedge clk) disable iff (rst)
        (wr_cm && !busy_i && drv_ready && !srst_i) |=> busy_i);

    a_r5_finish: assert property (@(posedge clk) disable iff (rst)
        (busy_i && drv_cmd_done && drv_ready && !drv_fault && !srst_i && !host_wr)
        |=> (!busy_i && intrq));

    a_r7_df_sticky: assert property (@(posedge clk) disable iff (rst)
        (df_i && !host_wr) |=> df_i);

    a_r9_nien_float: assert property (@(posedge clk) disable iff (rst)
        (wr_ct && host_wdata[CTL_NIEN_BIT]) |=> !intrq_oe);

    a_r10_srst_busy: assert property (@(posedge clk) disable iff (rst)
        (srst_i && rd_st) |-> host_rdata[7]);

    a_r12_head_inv: assert property (@(posedge clk) disable iff (rst)
        rd_dg |-> (host_rdata[5:2] == ~drv_head));
endmodule

bind tfs_ctrl tfs_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_cs0      (host_cs0),
    .host_cs1      (host_cs1),
    .host_addr     (host_addr),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .host_rdata_oe (host_rdata_oe),
    .intrq         (intrq),
    .intrq_oe      (intrq_oe),
    .drv_ready     (drv_ready),
    .drv_fault     (drv_fault),
    .drv_cmd_done  (drv_cmd_done),
    .drv_head      (drv_head),
    .busy_i        (busy_i),
    .df_i          (df_i),
    .srst_i        (srst_i)
);

// File: tb/tfs_ctrl_tb_top.sv
`timescale 1ns/1ps
module tfs_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_cs0 = 0, host_cs1 = 0, host_rd = 0, host_wr = 0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata, host_rdata_oe, cmd_code;
    logic       intrq, intrq_oe, cmd_start;
    logic       dev_is_slave = 0, drv_ready = 0, drv_fault = 0, drv_seek_done = 0;
    logic       drv_drq = 0, drv_index = 0, drv_wgate = 0, drv_cmd_done = 0;
    logic [3:0] drv_head = '0;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tfs_ctrl dut_i (
        .clk(clk), .rst(rst), .host_cs0(host_cs0), .host_cs1(host_cs1),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdata_oe(host_rdata_oe), .intrq(intrq), .intrq_oe(intrq_oe),
        .dev_is_slave(dev_is_slave), .drv_ready(drv_ready), .drv_fault(drv_fault),
        .drv_seek_done(drv_seek_done), .drv_drq(drv_drq), .drv_index(drv_index),
        .drv_wgate(drv_wgate), .drv_head(drv_head), .drv_cmd_done(drv_cmd_done),
        .cmd_start(cmd_start), .cmd_code(cmd_code)
    );

    function automatic logic [7:0] st(input bit bsy, drdy, df, dsc, drq, idx, err);
        return {bsy, drdy, df, dsc, drq, 1'b0, idx, err};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwr(input bit c0, input bit c1, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_cs0 = c0; host_cs1 = c1; host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk);
        host_wr = 0; host_cs0 = 0; host_cs1 = 0;
        @(negedge clk);
    endtask

    task automatic hrd(input bit c0, input bit c1, input logic [2:0] a,
                       output logic [7:0] d, output logic [7:0] oe);
        @(negedge clk);
        host_cs0 = c0; host_cs1 = c1; host_addr = a; host_rd = 1;
        #1;
        d = host_rdata; oe = host_rdata_oe;
        @(negedge clk);
        host_rd = 0; host_cs0 = 0; host_cs1 = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); drv_cmd_done = 1;
        @(negedge clk); drv_cmd_done = 0;
    endtask

    task automatic pulse_seek();
        @(negedge clk); drv_seek_done = 1;
        @(negedge clk); drv_seek_done = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d, oe;
        repeat (3) @(negedge clk);
        rst = 0;

        // reset state
        hrd(1, 0, 3'd7, d, oe);
        chk("R2 reset status", d, 8'h00);
        chk("R1 status oe", oe, 8'hFF);
        chk("R9 oe when selected", {7'd0, intrq_oe}, 8'd1);
        chk("R5 no irq at reset", {7'd0, intrq}, 8'd0);

        drv_ready = 1;
        @(negedge clk); @(negedge clk);
        hrd(1, 0, 3'd7, d, oe);
        chk("R6 dsc after ready", d, st(0,1,0,1,0,0,0));
        hrd(0, 0, 3'd7, d, oe);
        chk("R1 no cs oe", oe, 8'h00);
        hrd(1, 1, 3'd7, d, oe);
        chk("R1 both cs oe", oe, 8'h00);

        // seek-type command
        hwr(1, 0, 3'd7, 8'h20);
        hrd(1, 0, 3'd7, d, oe);
        chk("R6 dsc cleared by seek cmd", d, st(1,1,0,0,0,0,0));
        chk("R4 code latched", cmd_code, 8'h20);
        pulse_seek();
        hrd(1, 1'b0, 3'd7, d, oe);
        chk("R6 dsc set by seek done", d, st(1,1,0,1,0,0,0));
        pulse_done();
        chk("R5 irq after done", {7'd0, intrq}, 8'd1);
        hrd(0, 1, 3'd6, d, oe);
        chk("R3 alt byte", d, st(0,1,0,1,0,0,0));
        chk("R3 alt keeps irq", {7'd0, intrq}, 8'd1);
        hrd(1, 0, 3'd7, d, oe);
        chk("R3 status byte", d, st(0,1,0,1,0,0,0));
        chk("R3 status acks irq", {7'd0, intrq}, 8'd0);

        drv_drq = 1; drv_index = 1;
        hrd(0, 1, 3'd6, d, oe);
        chk("R2 drq idx live", d, st(0,1,0,1,1,1,0));
        drv_drq = 0; drv_index = 0;

        // interrupt disable
        hwr(0, 1, 3'd6, 8'h02);
        chk("R9 nien floats", {7'd0, intrq_oe}, 8'd0);
        hwr(1, 0, 3'd7, 8'h00);
        hrd(0, 1, 3'd6, d, oe);
        chk("R6 non-seek keeps dsc", d, st(1,1,0,1,0,0,0));
        pulse_done();
        chk("R9 pending under nien", {7'd0, intrq}, 8'd1);
        chk("R9 still floating", {7'd0, intrq_oe}, 8'd0);
        hwr(0, 1, 3'd6, 8'h00);
        chk("R9 re-enabled", {intrq_oe, intrq}, 8'd3);
        hwr(1, 0, 3'd7, 8'h00);
        chk("R4 cmd write clears irq", {7'd0, intrq}, 8'd0);
        pulse_done();
        hrd(1, 0, 3'd7, d, oe);

        // deselected
        hwr(1, 0, 3'd6, 8'h10);
        chk("R9 deselected floats", {7'd0, intrq_oe}, 8'd0);
        hrd(0, 1, 3'd7, d, oe);
        chk("R12 deselected diag", {1'b0, d[6:0]}, 8'h7F);
        chk("R1 diag oe", oe, 8'h7F);
        hwr(1, 0, 3'd6, 8'h00);
        chk("R9 selected again", {7'd0, intrq_oe}, 8'd1);

        // fault abort
        hwr(1, 0, 3'd7, 8'h70);
        @(negedge clk); drv_fault = 1;
        @(negedge clk); drv_fault = 0;
        hrd(0, 1, 3'd6, d, oe);
        chk("R7 fault abort", d, st(0,1,1,0,0,0,1));
        chk("R7 fault irq", {7'd0, intrq}, 8'd1);
        @(negedge clk); @(negedge clk);
        hrd(1, 0, 3'd7, d, oe);
        chk("R7 fault sticky", d, st(0,1,1,0,0,0,1));
        hwr(1, 0, 3'd7, 8'h00);
        hrd(1, 0, 3'd7, d, oe);
        chk("R7 cleared by next cmd", d, st(1,1,0,0,0,0,0));
        pulse_done();
        hrd(1, 0, 3'd7, d, oe);
        chk("R5 busy clear", d, st(0,1,0,0,0,0,0));

        // ready loss
        hwr(1, 0, 3'd7, 8'h00);
        @(negedge clk); drv_ready = 0;
        @(negedge clk);
        chk("R8 irq on ready loss", {7'd0, intrq}, 8'd1);
        hrd(1, 0, 3'd7, d, oe);
        chk("R8 abort status", d, st(0,0,0,0,0,0,1));
        hwr(1, 0, 3'd7, 8'h00);
        hrd(1, 0, 3'd7, d, oe);
        chk("R4 not-ready cmd ignored", d, st(0,0,0,0,0,0,1));
        drv_ready = 1;
        @(negedge clk);

        // soft reset with the other drive selected
        hwr(1, 0, 3'd6, 8'h10);
        hwr(0, 1, 3'd6, 8'h04);
        hrd(1, 0, 3'd7, d, oe);
        chk("R10 srst status", d, st(1,1,0,0,0,0,0));
        hwr(0, 1, 3'd6, 8'h00);
        hrd(1, 0, 3'd7, d, oe);
        chk("R10 after release", d, st(0,1,0,1,0,0,0));
        chk("R10 select reset", {7'd0, intrq_oe}, 8'd1);

        // ignored control bits
        hwr(0, 1, 3'd6, 8'hF9);
        chk("R11 ignored bits oe", {7'd0, intrq_oe}, 8'd1);
        hrd(1, 0, 3'd7, d, oe);
        chk("R11 ignored bits status", d, st(0,1,0,1,0,0,0));

        // diagnostic sweep, master strap
        for (int h = 0; h < 16; h++) begin
            drv_head = h[3:0]; drv_wgate = h[0];
            hrd(0, 1, 3'd7, d, oe);
            chk("R12 master diag", {1'b0, d[6:0]},
                {1'b0, ~h[0], 4'hF - h[3:0], 2'b10});
        end
        // slave strap
        dev_is_slave = 1;
        hwr(1, 0, 3'd6, 8'h10);
        chk("R9 slave selected", {7'd0, intrq_oe}, 8'd1);
        for (int h = 0; h < 16; h++) begin
            drv_head = h[3:0]; drv_wgate = ~h[0];
            hrd(0, 1, 3'd7, d, oe);
            chk("R12 slave diag", {1'b0, d[6:0]},
                {1'b0, h[0], 4'hF - h[3:0], 2'b01});
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule